// File: doc/BRIEF.md
# Periodic Subarray Test Sequencer

This block drives a one-dimensional bilateral bit-level array through a test. In this array every cell latches its two horizontal outputs, and only the two end outputs can be seen. The host stores a short stimulus program for one target state. The program has M steps, and each step holds one vertical-input pattern that is 2M+1 bits wide. The host also stores a left and a right boundary bit for every (offset, step) pair, and an expected pair of end-output bits for every (offset, observation cycle) pair. After a start request, the sequencer treats the N-cell array as back-to-back windows of 2M+1 cells. It copies the current step's pattern into every window, so that one cell per window reaches the target state at the same moment.

Each pass has three parts. It begins with a one-cycle array reset. Next comes a control phase of M cycles, during which the tiled pattern and the boundary streams are driven. Last comes an observation phase of N cycles, during which the two end outputs are compared against the expected stream. The pass is repeated for every target offset i from 0 to 2M. For offset i the tiled pattern is rotated so that the pattern's centre lands on window position i. The boundary streams belong to each offset, which lets the host supply the left-edge feed that matches the rotation and the right-edge feed that stands in for the missing neighbour of a short last window. A mismatch latches a sticky failure with its offset and cycle, and a per-offset pass vector records which offsets ran clean.

Top module: `subarray_test_seq`

## Requirements
- R1: After reset, busy, done, fail and pass_vec are 0, and arr_rst, arr_vert, arr_left_in and arr_right_in are all 0.
- R2: Every offset pass begins with arr_rst high for exactly one cycle. M control cycles follow, then N observation cycles. Offsets run in order 0, 1, ..., 2M, so a run takes (2M+1)(1+M+N) cycles.
- R3: Let S=2M+1. In control step k of offset i, cell c is driven with bit p=((c mod S) - i + M) mod S of the stored step-k pattern. The same pattern is applied to every window in the same cycle.
- R4: In control step k, a pattern position p is driven only if k <= p <= 2M-k and p-k is even. Any other position is driven 0, whatever the stored bit.
- R5: In control step k of offset i, arr_left_in and arr_right_in carry bit 1 and bit 0 of boundary entry i*M+k. Outside the control phase both are 0.
- R6: In the observation phase, arr_vert, arr_left_in and arr_right_in are 0. In observation cycle j of offset i, {arr_left_out, arr_right_out} sampled at the clock edge that ends the cycle is compared with expected entry i*N+j (bit 1 left, bit 0 right).
- R7: The first mismatch sets fail and records fail_offset and fail_cycle. All three hold until the next accepted start, which clears them.
- R8: pass_vec bit i is set when offset i completes with no mismatch, and stays 0 otherwise. Starting a run clears pass_vec.
- R9: busy rises on the clock edge that accepts start and falls after the last observation cycle. At that point done rises and stays high until the next accepted start.
- R10: A write with wr_en takes its target from wr_sel: 0 selects pattern step wr_addr (data bits S-1..0), 1 selects boundary entry wr_addr, and 2 selects expected entry wr_addr (data bits 1..0). Writes made while busy are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins a run when idle |
| busy | output | 1 | Run in progress |
| done | output | 1 | Last run finished |
| wr_en | input | 1 | Program write strobe |
| wr_sel | input | 2 | Write target: 0 pattern, 1 boundary, 2 expected |
| wr_addr | input | clog2(S*N) | Write address |
| wr_data | input | S | Write data |
| arr_rst | output | 1 | Global reset to the array latches |
| arr_vert | output | N | Vertical inputs, one per cell |
| arr_left_in | output | 1 | Left-end horizontal input |
| arr_right_in | output | 1 | Right-end horizontal input |
| arr_left_out | input | 1 | Left-end output of the array |
| arr_right_out | input | 1 | Right-end output of the array |
| fail | output | 1 | Sticky mismatch flag |
| fail_offset | output | clog2(S) | Offset of first mismatch |
| fail_cycle | output | clog2(N) | Observation cycle of first mismatch |
| pass_vec | output | S | Per-offset clean result |

## Verification
The bench uses an array length that is not a multiple of the window size, so the short last window shows whether the rotation wraps correctly per cell. It stores an all-ones pattern, whose drive shows the window mask alone. It then stores irregular patterns, which also expose a wrong rotation direction or a wrong centre. Boundary bits vary with both offset and step, so a swapped index or a left/right swap shows up. The three runs are a fully matching response stream, a stream with one corrupted expected entry (which tells the recorded offset and cycle apart from neighbouring ones and confirms that later matches leave the flag set), and a clean rerun, which shows that the flag is cleared. A pattern write made in the middle of a run must not change the drive of any later offset.

// File: rtl/sts_pkg.sv
package sts_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_RST  = 2'd1,
      ST_CTRL = 2'd2,
      ST_OBS  = 2'd3
   } sts_state_e;

   localparam logic [1:0] SEL_PATTERN  = 2'd0;
   localparam logic [1:0] SEL_BOUNDARY = 2'd1;
   localparam logic [1:0] SEL_EXPECT   = 2'd2;

   // Pattern index for a window-local cell when the centre is moved to offset off.
   function automatic int tile_pos(input int loc, input int off, input int m);
      int s;
      int p;
      s = 2 * m + 1;
      p = loc + s + m - off;
      if (p >= s) p = p - s;
      if (p >= s) p = p - s;
      return p;
   endfunction

   // Whether pattern position p carries a meaningful bit at step k.
   function automatic bit in_window(input int k, input int p, input int m);
      return (p >= k) && (p <= 2 * m - k) && (((p - k) % 2) == 0);
   endfunction

endpackage

// File: rtl/sts_stim_store.sv
module sts_stim_store #(
   parameter int M  = 2,
   parameter int S  = 5,
   parameter int AW = 6,
   parameter int SW = 1,
   parameter int OW = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_ok,
   input  logic [1:0]    wr_sel,
   input  logic [AW-1:0] wr_addr,
   input  logic [S-1:0]  wr_data,
   input  logic [SW-1:0] step,
   input  logic [OW-1:0] off,
   output logic [S-1:0]  pat_row,
   output logic [1:0]    bnd_bits
);
   localparam int BN = S * M;
   localparam int BW = $clog2(BN);

   logic [S-1:0] pat_mem [M];
   logic [1:0]   bnd_mem [BN];
   logic [BW-1:0] bidx;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < M; k++) pat_mem[k] <= '0;
         for (int e = 0; e < BN; e++) bnd_mem[e] <= '0;
      end else if (wr_ok) begin
         if (wr_sel == sts_pkg::SEL_PATTERN && int'(wr_addr) < M)
            pat_mem[SW'(wr_addr)] <= wr_data;
         else if (wr_sel == sts_pkg::SEL_BOUNDARY && int'(wr_addr) < BN)
            bnd_mem[BW'(wr_addr)] <= wr_data[1:0];
      end
   end

   assign bidx     = BW'(int'(off) * M + int'(step));
   assign pat_row  = pat_mem[step];
   assign bnd_bits = bnd_mem[bidx];

endmodule

// File: rtl/sts_tile_drive.sv
module sts_tile_drive #(
   parameter int M  = 2,
   parameter int N  = 12,
   parameter int S  = 5,
   parameter int SW = 1,
   parameter int OW = 3
) (
   input  logic          en,
   input  logic [SW-1:0] step,
   input  logic [OW-1:0] off,
   input  logic [S-1:0]  pat_row,
   output logic [N-1:0]  arr_vert
);
   localparam int PW = $clog2(S);

   for (genvar c = 0; c < N; c++) begin : g_cell
      localparam int LOC = c % S;
      int pos;
      assign pos = sts_pkg::tile_pos(LOC, int'(off), M);
      assign arr_vert[c] = en
                           && sts_pkg::in_window(int'(step), pos, M)
                           && pat_row[PW'(pos)];
   end

endmodule

// File: rtl/sts_resp_check.sv
module sts_resp_check #(
   parameter int N  = 12,
   parameter int S  = 5,
   parameter int AW = 6,
   parameter int OW = 3,
   parameter int CW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_ok,
   input  logic [AW-1:0] wr_addr,
   input  logic [1:0]    wr_data,
   input  logic          clear,
   input  logic          active,
   input  logic          last,
   input  logic [OW-1:0] off,
   input  logic [CW-1:0] obs,
   input  logic          lo,
   input  logic          ro,
   output logic          fail,
   output logic [OW-1:0] fail_offset,
   output logic [CW-1:0] fail_cycle,
   output logic [S-1:0]  pass_vec
);
   localparam int EN = S * N;
   localparam int EW = $clog2(EN);

   logic [1:0]    exp_mem [EN];
   logic [EW-1:0] ridx;
   logic          mism;
   logic          err_cur;

   always_ff @(posedge clk) begin
      if (wr_ok && int'(wr_addr) < EN)
         exp_mem[EW'(wr_addr)] <= wr_data;
   end

   assign ridx = EW'(int'(off) * N + int'(obs));
   assign mism = active && ({lo, ro} != exp_mem[ridx]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fail        <= 1'b0;
         fail_offset <= '0;
         fail_cycle  <= '0;
         pass_vec    <= '0;
         err_cur     <= 1'b0;
      end else if (clear) begin
         fail        <= 1'b0;
         fail_offset <= '0;
         fail_cycle  <= '0;
         pass_vec    <= '0;
         err_cur     <= 1'b0;
      end else begin
         if (mism && !fail) begin
            fail        <= 1'b1;
            fail_offset <= off;
            fail_cycle  <= obs;
         end
         if (active) begin
            if (last) begin
               pass_vec[off] <= !(err_cur || mism);
               err_cur       <= 1'b0;
            end else if (mism) begin
               err_cur <= 1'b1;
            end
         end
      end
   end

   // R7: once set, the flag and its record persist until a new run clears them
   a_r7_fail_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (fail && !clear) |=> fail);
   a_r7_record_held: assert property (@(posedge clk) disable iff (!rst_n)
      (fail && !clear) |=> ($stable(fail_offset) && $stable(fail_cycle)));
   // R8: pass bits only change at the close of an observation phase or on clear
   a_r8_pass_update: assert property (@(posedge clk) disable iff (!rst_n)
      (!clear && !(active && last)) |=> $stable(pass_vec));

endmodule

// File: rtl/subarray_test_seq.sv
module subarray_test_seq #(
   parameter int M = 2,
   parameter int N = 12,
   localparam int S  = 2 * M + 1,
   localparam int AW = $clog2(S * N),
   localparam int OW = $clog2(S),
   localparam int CW = $clog2(N)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   output logic          busy,
   output logic          done,
   input  logic          wr_en,
   input  logic [1:0]    wr_sel,
   input  logic [AW-1:0] wr_addr,
   input  logic [S-1:0]  wr_data,
   output logic          arr_rst,
   output logic [N-1:0]  arr_vert,
   output logic          arr_left_in,
   output logic          arr_right_in,
   input  logic          arr_left_out,
   input  logic          arr_right_out,
   output logic          fail,
   output logic [OW-1:0] fail_offset,
   output logic [CW-1:0] fail_cycle,
   output logic [S-1:0]  pass_vec
);
   import sts_pkg::*;

   localparam int SW = (M > 1) ? $clog2(M) : 1;
   localparam logic [SW-1:0] LAST_STEP = SW'(M - 1);
   localparam logic [CW-1:0] LAST_OBS  = CW'(N - 1);
   localparam logic [OW-1:0] LAST_OFF  = OW'(S - 1);

   if (M < 1) begin : g_bad_m
      $error("subarray_test_seq: M must be at least 1");
   end
   if (N < S) begin : g_bad_n
      $error("subarray_test_seq: N must cover at least one window of 2M+1 cells");
   end

   sts_state_e    st;
   logic [OW-1:0] off;
   logic [SW-1:0] step;
   logic [CW-1:0] obs;
   logic          done_q;
   logic          accept;
   logic          in_ctrl;
   logic          in_obs;
   logic [S-1:0]  pat_row;
   logic [1:0]    bnd_bits;
   logic          wr_stim;
   logic          wr_exp;

   assign accept  = (st == ST_IDLE) && start;
   assign in_ctrl = (st == ST_CTRL);
   assign in_obs  = (st == ST_OBS);
   assign busy    = (st != ST_IDLE);
   assign done    = done_q;
   assign wr_stim = wr_en && !busy;
   assign wr_exp  = wr_en && !busy && (wr_sel == SEL_EXPECT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= ST_IDLE;
         off    <= '0;
         step   <= '0;
         obs    <= '0;
         done_q <= 1'b0;
      end else begin
         unique case (st)
            ST_IDLE: if (start) begin
               st     <= ST_RST;
               off    <= '0;
               done_q <= 1'b0;
            end
            ST_RST: begin
               st   <= ST_CTRL;
               step <= '0;
            end
            ST_CTRL: if (step == LAST_STEP) begin
               st  <= ST_OBS;
               obs <= '0;
            end else begin
               step <= step + 1'b1;
            end
            ST_OBS: if (obs == LAST_OBS) begin
               if (off == LAST_OFF) begin
                  st     <= ST_IDLE;
                  done_q <= 1'b1;
               end else begin
                  st  <= ST_RST;
                  off <= off + 1'b1;
               end
            end else begin
               obs <= obs + 1'b1;
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   assign arr_rst      = (st == ST_RST);
   assign arr_left_in  = in_ctrl && bnd_bits[1];
   assign arr_right_in = in_ctrl && bnd_bits[0];

   sts_stim_store #(.M(M), .S(S), .AW(AW), .SW(SW), .OW(OW)) i_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_ok    (wr_stim),
      .wr_sel   (wr_sel),
      .wr_addr  (wr_addr),
      .wr_data  (wr_data),
      .step     (step),
      .off      (off),
      .pat_row  (pat_row),
      .bnd_bits (bnd_bits)
   );

   sts_tile_drive #(.M(M), .N(N), .S(S), .SW(SW), .OW(OW)) i_tile (
      .en       (in_ctrl),
      .step     (step),
      .off      (off),
      .pat_row  (pat_row),
      .arr_vert (arr_vert)
   );

   sts_resp_check #(.N(N), .S(S), .AW(AW), .OW(OW), .CW(CW)) i_check (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_ok       (wr_exp),
      .wr_addr     (wr_addr),
      .wr_data     (wr_data[1:0]),
      .clear       (accept),
      .active      (in_obs),
      .last        (obs == LAST_OBS),
      .off         (off),
      .obs         (obs),
      .lo          (arr_left_out),
      .ro          (arr_right_out),
      .fail        (fail),
      .fail_offset (fail_offset),
      .fail_cycle  (fail_cycle),
      .pass_vec    (pass_vec)
   );

   // R2: array reset is a single-cycle pulse followed by the first control step
   a_r2_rst_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      arr_rst |=> (!arr_rst && in_ctrl && step == '0));
   // R2: observation is entered only from the last control step
   a_r2_ctrl_len: assert property (@(posedge clk) disable iff (!rst_n)
      (in_obs && $past(in_ctrl)) |-> ($past(step) == LAST_STEP));
   // R6: nothing is driven into the array while observing
   a_r6_obs_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      in_obs |-> (arr_vert == '0 && !arr_left_in && !arr_right_in));
   // R9: done and busy never overlap
   a_r9_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);
   // R2: offset counter stays inside the window
   a_r2_off_range: assert property (@(posedge clk) disable iff (!rst_n)
      int'(off) < S);

endmodule

// File: tb/test_subarray_test_seq.sv
module test_subarray_test_seq;
   localparam int M = 2;
   localparam int N = 12;
   localparam int S = 2 * M + 1;
   localparam int AW = $clog2(S * N);
   localparam int OW = $clog2(S);
   localparam int CW = $clog2(N);
   localparam int CLK_PERIOD = 10;

   typedef struct {
      logic         rst;
      logic [N-1:0] vert;
      logic         li;
      logic         ri;
      logic         lo;
      logic         ro;
      string        tag;
   } item_t;

   logic clk = 0;
   logic rst_n = 0;
   logic start = 0;
   logic wr_en = 0;
   logic [1:0] wr_sel = 0;
   logic [AW-1:0] wr_addr = 0;
   logic [S-1:0] wr_data = 0;
   logic arr_left_out = 0;
   logic arr_right_out = 0;
   logic busy, done, arr_rst, arr_left_in, arr_right_in, fail;
   logic [N-1:0] arr_vert;
   logic [OW-1:0] fail_offset;
   logic [CW-1:0] fail_cycle;
   logic [S-1:0] pass_vec;

   int n_checks = 0;
   int n_fail = 0;
   item_t q[$];
   logic [S-1:0] pat_b [M];
   logic lb [S][M];
   logic rb [S][M];
   logic resp_l [S][N];
   logic resp_r [S][N];

   always #(CLK_PERIOD / 2) clk = ~clk;

   subarray_test_seq #(.M(M), .N(N)) i_subarray_test_seq (
      .clk, .rst_n, .start, .busy, .done, .wr_en, .wr_sel, .wr_addr, .wr_data,
      .arr_rst, .arr_vert, .arr_left_in, .arr_right_in, .arr_left_out,
      .arr_right_out, .fail, .fail_offset, .fail_cycle, .pass_vec
   );

   task automatic chk(input bit ok, input string req, input logic [63:0] act,
                      input logic [63:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // Drive computed from the tiling and masking rules of R3 and R4
   function automatic logic [N-1:0] exp_vert(input int k, input int off);
      logic [N-1:0] v;
      for (int c = 0; c < N; c++) begin
         int p;
         bit live;
         p = ((c % S) - off + M + 2 * S) % S;
         live = (p >= k) && (p <= 2 * M - k) && (((p - k) % 2) == 0);
         v[c] = live && pat_b[k][p];
      end
      return v;
   endfunction

   task automatic wr(input logic [1:0] sel, input int addr, input logic [S-1:0] data);
      @(negedge clk);
      wr_en = 1; wr_sel = sel; wr_addr = AW'(addr); wr_data = data;
      @(negedge clk);
      wr_en = 0;
   endtask

   task automatic load_all(input int bad_off, input int bad_cyc);
      for (int k = 0; k < M; k++) wr(2'd0, k, pat_b[k]);
      for (int o = 0; o < S; o++)
         for (int k = 0; k < M; k++)
            wr(2'd1, o * M + k, S'({lb[o][k], rb[o][k]}));
      for (int o = 0; o < S; o++)
         for (int j = 0; j < N; j++) begin
            logic el;
            el = resp_l[o][j] ^ ((o == bad_off) && (j == bad_cyc));
            wr(2'd2, o * N + j, S'({el, resp_r[o][j]}));
         end
   endtask

   // Scoreboard driver: expected array-side activity for a whole run
   task automatic push_run();
      for (int o = 0; o < S; o++) begin
         item_t it;
         it = '{rst: 1, vert: '0, li: 0, ri: 0, lo: 0, ro: 0, tag: "R2"};
         q.push_back(it);
         for (int k = 0; k < M; k++) begin
            it = '{rst: 0, vert: exp_vert(k, o), li: lb[o][k], ri: rb[o][k],
                   lo: 0, ro: 0, tag: "R3 R4 R5"};
            q.push_back(it);
         end
         for (int j = 0; j < N; j++) begin
            it = '{rst: 0, vert: '0, li: 0, ri: 0, lo: resp_l[o][j],
                   ro: resp_r[o][j], tag: "R6"};
            q.push_back(it);
         end
      end
   endtask

   // Monitor: compare each busy cycle and act as the array's end outputs
   always @(negedge clk) begin
      if (rst_n && busy) begin
         if (q.size() == 0) begin
            chk(0, "R2 run length", 1, 0);
         end else begin
            item_t it;
            it = q.pop_front();
            chk(arr_rst === it.rst && arr_vert === it.vert &&
                arr_left_in === it.li && arr_right_in === it.ri, it.tag,
                {arr_rst, arr_left_in, arr_right_in, arr_vert},
                {it.rst, it.li, it.ri, it.vert});
            arr_left_out = it.lo;
            arr_right_out = it.ro;
         end
      end else begin
         arr_left_out = 0;
         arr_right_out = 0;
      end
   end

   task automatic run_and_wait(input bit poke_busy);
      @(negedge clk);
      start = 1;
      @(negedge clk);
      start = 0;
      chk(busy === 1'b1 && done === 1'b0, "R9 busy after start", {busy, done}, 2'b10);
      chk(fail === 1'b0 && pass_vec === '0, "R7 cleared by start", {fail, pass_vec}, 0);
      if (poke_busy) begin
         repeat (3) @(negedge clk);
         // R10: pattern write while busy must not change later drive
         wr_en = 1; wr_sel = 2'd0; wr_addr = '0; wr_data = '0;
         @(negedge clk);
         wr_en = 0;
      end
      wait (done === 1'b1);
      @(negedge clk);
      chk(q.size() == 0, "R2 all cycles seen", q.size(), 0);
      chk(busy === 1'b0 && done === 1'b1, "R9 done after run", {busy, done}, 2'b01);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      n_fail++;
      n_checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      for (int o = 0; o < S; o++) begin
         for (int k = 0; k < M; k++) begin
            lb[o][k] = ((o + k) % 2) == 1;
            rb[o][k] = ((o * 3 + k) % 4) >= 2;
         end
         for (int j = 0; j < N; j++) begin
            resp_l[o][j] = ((o + j) % 3) == 0;
            resp_r[o][j] = ((o * j + 1) % 2) == 1;
         end
      end
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(busy === 0 && done === 0 && fail === 0 && pass_vec === '0, "R1 status",
          {busy, done, fail, pass_vec}, 0);
      chk(arr_rst === 0 && arr_vert === '0 && arr_left_in === 0 && arr_right_in === 0,
          "R1 array drive", {arr_rst, arr_left_in, arr_right_in, arr_vert}, 0);
      rst_n = 1;
      @(negedge clk);

      // Run 1: all-ones pattern shows the mask; matching responses
      pat_b[0] = '1;
      pat_b[1] = '1;
      load_all(-1, -1);
      push_run();
      run_and_wait(1'b1);
      chk(fail === 1'b0, "R7 no mismatch", fail, 0);
      chk(pass_vec === 5'b11111, "R8 all offsets clean", pass_vec, 5'b11111);

      // Run 2: irregular patterns, one corrupted expectation at offset 3 cycle 7
      pat_b[0] = 5'b10110;
      pat_b[1] = 5'b01011;
      for (int o = 0; o < S; o++)
         for (int k = 0; k < M; k++) rb[o][k] = ((o + 2 * k) % 3) == 1;
      load_all(3, 7);
      push_run();
      run_and_wait(1'b0);
      chk(fail === 1'b1, "R7 fail latched and kept", fail, 1);
      chk(fail_offset === OW'(3), "R7 fail offset", fail_offset, 3);
      chk(fail_cycle === CW'(7), "R7 fail cycle", fail_cycle, 7);
      chk(pass_vec === 5'b10111, "R8 only offset 3 fails", pass_vec, 5'b10111);

      // Run 3: correct expectations again; start must clear the failure record
      wr(2'd2, 3 * N + 7, S'({resp_l[3][7], resp_r[3][7]}));
      // R10: check the write select decoding of expected entries at the ports
      push_run();
      run_and_wait(1'b0);
      chk(fail === 1'b0 && fail_offset === '0 && fail_cycle === '0, "R7 cleared",
          {fail, fail_offset, fail_cycle}, 0);
      chk(pass_vec === 5'b11111, "R8 clean rerun", pass_vec, 5'b11111);

      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

endmodule